// File: doc/BRIEF.md
# Gated Pulse Rate Meter

This block estimates how often a trigger line pulses. The line arrives with no known relation to the system clock. The block synchronises it, detects its rising edges and counts them over a gate of fixed duration. When a gate closes, the count is published as the rate result, and a 16-bit sequence number steps so that software can tell a fresh reading from a stale one. A free-running total of all detected edges is kept next to the result.

The gate duration is picked from four fixed values with a 2-bit select. The select is sampled only when a gate closes, so a gate that is already running keeps its length. Gate lengths in clock cycles are derived from the `CLK_HZ` parameter. A small `CLK_HZ` gives short gates in simulation.

Top module: `pulse_rate_meter`

## Requirements
- R1: While `rst_ni` is low, `rate_o`, `seq_o` and `total_o` are zero. The first gate after reset uses select code 00.
- R2: A gate lasts `CLK_HZ/2000` clock cycles for code 00, `CLK_HZ/20` for 01, `5*CLK_HZ` for 10 and `20*CLK_HZ` for 11. These are 500 us, 50 ms, 5 s and 20 s.
- R3: `gate_sel_i` is sampled only on the last cycle of a gate, and the sampled value sets the length of the next gate. Changes in the middle of a gate do not alter that gate's length.
- R4: When a gate closes, `rate_o` takes the number of rising edges detected during that gate. At all other times `rate_o` holds its value.
- R5: `seq_o` rises by exactly one on the clock edge where `rate_o` is published, and wraps from 65535 to 0.
- R6: `total_o` rises by one for every detected rising edge and by nothing otherwise, wrapping at 2^32.
- R7: An edge detected on a gate's last cycle belongs to that gate. The next gate starts counting from zero.
- R8: `pulse_async_i` passes two synchronising flops before edge detection. A level held high for many cycles is counted once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_async_i | input | 1 | Trigger line to be measured, asynchronous |
| gate_sel_i | input | 2 | Gate length code (00, 01, 10, 11) |
| rate_o | output | 32 | Edge count of the last closed gate |
| seq_o | output | 16 | Result sequence number |
| total_o | output | 32 | Running count of all detected edges |

## Verification
Three things can land on the same clock edge: a gate closing, a detected edge, and a new select being latched. With the 1-cycle gate of code 00, every cycle is a last cycle. A toggling trigger therefore puts an edge on a gate boundary again and again. The bench sums the published rates and requires the sum to equal the growth of the total. Select changes are made right after a gate opens and in its middle. The measured gate intervals, the published counts and a per-cycle behavioural model judge whether the old gate kept its length and the edge went to the closing gate.

// File: rtl/prm_pkg.sv
package prm_pkg;

  typedef enum logic [1:0] {
    GATE_500US = 2'b00,
    GATE_50MS  = 2'b01,
    GATE_5S    = 2'b10,
    GATE_20S   = 2'b11
  } gate_code_e;

  // Gate length in clock cycles for a given clock rate and select code.
  function automatic longint unsigned gate_cycles(input longint unsigned hz,
                                                  input logic [1:0] code);
    longint unsigned len;
    case (code)
      GATE_500US: len = hz / 2000;
      GATE_50MS:  len = hz / 20;
      GATE_5S:    len = hz * 5;
      default:    len = hz * 20;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/prm_edge_sync.sv
module prm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              last_q, last_d;

  always_comb begin
    chain_d[0] = async_i;
    last_d     = chain_q[STAGES-1];
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    assign chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  // R8: a single synchronised rise is reported for one cycle only
  a_r8_single_cycle_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/prm_gate_timer.sv
module prm_gate_timer #(
  parameter longint unsigned CLK_HZ = 100_000_000,
  parameter int unsigned     TW     = 31
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  output logic       gate_end_o
);

  logic [TW-1:0] last_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_len
    assign last_tab[g] = TW'(prm_pkg::gate_cycles(CLK_HZ, 2'(g)) - 1);
  end

  logic [1:0]    sel_q, sel_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          at_last;
  logic          sel_en;

  always_comb begin
    at_last = (cnt_q == last_tab[sel_q]);
    sel_en  = at_last;
    sel_d   = sel_i;
    cnt_d   = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= prm_pkg::GATE_500US;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign gate_end_o = at_last;

  // R2: the cycle counter never runs past the active gate's last cycle
  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_tab[sel_q]);

  // R3: the active code only moves when a gate closes
  a_r3_code_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_end_o |=> $stable(sel_q));

endmodule

// File: rtl/prm_rate_accum.sv
module prm_rate_accum #(
  parameter int unsigned CW = 32,
  parameter int unsigned GW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          gate_end_i,
  output logic [CW-1:0] rate_o,
  output logic [GW-1:0] seq_o,
  output logic [CW-1:0] total_o
);

  logic [CW-1:0] win_q, win_d;
  logic [CW-1:0] rate_q, rate_d;
  logic [CW-1:0] tot_q, tot_d;
  logic [GW-1:0] seq_q, seq_d;
  logic [CW-1:0] step;
  logic          pub_en;
  logic          tot_en;

  always_comb begin
    step   = CW'(rise_i);
    pub_en = gate_end_i;
    tot_en = rise_i;
    tot_d  = tot_q + step;
    rate_d = win_q + step;         // edge on the last cycle joins this gate
    seq_d  = seq_q + 1'b1;
    win_d  = gate_end_i ? '0 : win_q + step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
    end else begin
      win_q <= win_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      seq_q  <= '0;
    end else if (pub_en) begin
      rate_q <= rate_d;
      seq_q  <= seq_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tot_q <= '0;
    end else if (tot_en) begin
      tot_q <= tot_d;
    end
  end

  assign rate_o  = rate_q;
  assign seq_o   = seq_q;
  assign total_o = tot_q;

  // R4: result is frozen between gate closures
  a_r4_rate_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_end_i |=> $stable(rate_o));

  // R5: sequence number steps by one per publication
  a_r5_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_end_i |=> seq_o == GW'($past(seq_o) + 1'b1));

  // R5: sequence number is frozen otherwise
  a_r5_seq_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_end_i |=> $stable(seq_o));

  // R6: total follows detected edges exactly
  a_r6_total_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> total_o == CW'($past(total_o) + 1'b1));

  a_r6_total_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(total_o));

endmodule

// File: rtl/pulse_rate_meter.sv
module pulse_rate_meter #(
  parameter longint unsigned CLK_HZ = 100_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pulse_async_i,
  input  logic [1:0]  gate_sel_i,
  output logic [31:0] rate_o,
  output logic [15:0] seq_o,
  output logic [31:0] total_o
);

  localparam longint unsigned LEN_MAX   = prm_pkg::gate_cycles(CLK_HZ, 2'b11);
  localparam int unsigned     TW        = $clog2(LEN_MAX + 1);
  localparam int unsigned     CW        = 32;
  localparam int unsigned     GW        = 16;
  localparam int unsigned     SYNC_LVLS = 2;

  logic rise;
  logic gate_end;

  prm_edge_sync #(.STAGES(SYNC_LVLS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pulse_async_i),
    .rise_o  (rise)
  );

  prm_gate_timer #(.CLK_HZ(CLK_HZ), .TW(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (gate_sel_i),
    .gate_end_o (gate_end)
  );

  prm_rate_accum #(.CW(CW), .GW(GW)) u_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .gate_end_i (gate_end),
    .rate_o     (rate_o),
    .seq_o      (seq_o),
    .total_o    (total_o)
  );

endmodule

// File: tb/pulse_rate_meter_test.sv
module pulse_rate_meter_test;

  localparam longint unsigned HZ = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse = 1'b0;
  logic [1:0]  gsel = 2'b00;
  logic [31:0] rate;
  logic [15:0] seq;
  logic [31:0] total;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  pulse_rate_meter #(.CLK_HZ(HZ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pulse_async_i(pulse), .gate_sel_i(gsel),
    .rate_o(rate), .seq_o(seq), .total_o(total)
  );

  function automatic int glen(input logic [1:0] c);
    case (c)
      2'b00: return int'(HZ / 2000);
      2'b01: return int'(HZ / 20);
      2'b10: return int'(HZ * 5);
      default: return int'(HZ * 20);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  bit      m_a, m_b, m_c;
  longint  m_total, m_win, m_rate, m_seq, m_cnt;
  logic [1:0] m_act;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_c = 0;
      m_total = 0; m_win = 0; m_rate = 0; m_seq = 0; m_cnt = 0; m_act = 2'b00;
    end else begin
      bit e;
      e = m_b && !m_c;
      m_c = m_b; m_b = m_a; m_a = pulse;
      if (e) m_total = (m_total + 1) % 64'h1_0000_0000;
      if (m_cnt == glen(m_act) - 1) begin
        m_rate = m_win + e;        // R7: last-cycle edge goes to the closing gate
        m_win  = 0;
        m_seq  = (m_seq + 1) % 65536;
        m_cnt  = 0;
        m_act  = gsel;
      end else begin
        m_win = m_win + e;
        m_cnt = m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rate == m_rate, "R4 rate vs model", rate, m_rate);
      check(seq == m_seq, "R5 seq vs model", seq, m_seq);
      check(total == m_total, "R6 total vs model", total, m_total);
    end
  end

  task automatic wait_pub(output int n);
    logic [15:0] prev;
    prev = seq;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (seq == prev);
  endtask

  task automatic measure(input logic [1:0] code, input logic [1:0] nxt, input string req);
    int n;
    gsel = code;
    wait_pub(n);
    gsel = nxt;
    wait_pub(n);
    check(n == glen(code), req, n, glen(code));
  endtask

  initial begin
    int n;
    longint t0, sum;
    logic [15:0] s0;
    repeat (3) @(negedge clk);
    check(rate == 0 && total == 0, "R1 reset rate/total", rate + total, 0);
    check(seq == 0, "R1 reset seq", seq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(seq == 1, "R1 first gate is code 00", seq, 1);

    // R2: each code's gate length
    measure(2'b01, 2'b01, "R2 code 01");
    measure(2'b10, 2'b01, "R2 code 10");
    measure(2'b11, 2'b00, "R2 code 11");
    measure(2'b00, 2'b00, "R2 code 00");

    // R3: mid-gate changes leave the running gate alone
    gsel = 2'b01;
    wait_pub(n);
    repeat (30) @(negedge clk);
    gsel = 2'b10;
    repeat (20) @(negedge clk);
    gsel = 2'b00;
    wait_pub(n);
    check(n == glen(2'b01) - 50, "R3 gate kept length", n, glen(2'b01) - 50);
    wait_pub(n);
    check(n == glen(2'b00), "R3 latched code used next", n, glen(2'b00));

    // R4 and R6: five clean pulses in one 01 gate
    gsel = 2'b01;
    wait_pub(n);
    wait_pub(n);
    t0 = total;
    for (int i = 0; i < 5; i++) begin
      pulse = 1'b1; repeat (2) @(negedge clk);
      pulse = 1'b0; repeat (3) @(negedge clk);
    end
    wait_pub(n);
    check(rate == 5, "R4 five pulses counted", rate, 5);
    check(total - t0 == 5, "R6 total grew by five", total - t0, 5);

    // R8: a long high level is one edge
    wait_pub(n);
    pulse = 1'b1; repeat (40) @(negedge clk);
    pulse = 1'b0;
    wait_pub(n);
    check(rate == 1, "R8 held level counted once", rate, 1);

    // R7: 1-cycle gates, edges always on a gate's last cycle
    gsel = 2'b00;
    wait_pub(n);
    wait_pub(n);
    t0 = total;
    sum = 0;
    for (int i = 0; i < 80; i++) begin
      pulse = (i % 4) < 2;
      @(negedge clk);
      sum += rate;
    end
    pulse = 1'b0;
    check(sum == total - t0, "R7 boundary edges kept", sum, total - t0);
    check(sum > 10, "R7 edges were seen", sum, 20);

    // R5: wrap of the sequence number after 2^16 publications
    s0 = seq;
    repeat (65536) @(negedge clk);
    check(seq == s0, "R5 seq wraps at 2^16", seq, s0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule